// File: doc/BRIEF.md
# Three-Byte Converter Readout Sequencer

This block sits on the host side of a byte-wide analog-to-digital converter. It generates the active-low auto-zero request and the active-low convert strobes. It follows the converter's two-bit status code and opens the shared data bus with an active-low output enable. It reads the 22-bit result one byte per convert strobe, most significant byte first. The finished code is presented in two forms: bipolar offset binary, and signed two's complement. A one-cycle valid pulse marks each new result.

The host asks for a conversion with `start_i` and for an auto-zero with `azero_req_i`, and watches `busy_o`. The status code has these values:

- `00`: the converter is working.
- `01`: the top byte is on the bus.
- `10`: the middle byte is on the bus.
- `11`: the low byte is on the bus and the converter is ready.

Each wait for a status code is bounded by a timer. When the timer runs out, the cycle is abandoned and `err_o` is raised.

Top module: `adc_readout_ctrl`

## Requirements
- R1: While reset is held, `adc_conv_n_o`, `adc_oe_n_o` and `adc_az_n_o` are high, `valid_o` and `err_o` are low, and `busy_o` is high.
- R2: A start request is acted on only when the sequencer is idle, the filtered status reads `11` and no auto-zero is pending. Any other start request is dropped and produces no convert strobe.
- R3: Each convert strobe is low for exactly `CONV_LOW` clocks. A conversion uses three strobes. Before issuing the next strobe, or finishing, the sequencer waits for a specific status code: `01` after the first strobe, `10` after the second, `11` after the third.
- R4: For each of the three bytes, output enable is low for exactly `SETTLE` clocks and goes high again before the next strobe. It is never low while a convert strobe or an auto-zero request is low.
- R5: The result is assembled as {top byte bits 5:0, middle byte, low byte}. Bits 7:6 of the top byte have no effect on the result.
- R6: The signed output equals the offset-binary code minus 2^21, as a 24-bit two's complement value. So code 0x000000 gives -2097152, 0x200000 gives 0, and 0x3FFFFF gives 2097151.
- R7: `valid_o` is high for exactly one clock per completed conversion. Both result outputs hold their value until the next completed conversion.
- R8: An auto-zero request drives `adc_az_n_o` low for exactly `AZ_LOW` clocks. The sequencer then waits for status `00` followed by `11`. If an auto-zero request and a start request arrive in the same cycle, the auto-zero is performed and the start is dropped.
- R9: An auto-zero request made during a conversion is held pending, with `busy_o` high. It is carried out after that conversion completes.
- R10: If an awaited status code does not appear within `TIMEOUT` clocks, the sequencer returns to idle with all strobes high and sets `err_o`. `err_o` stays set until the next accepted start or auto-zero.
- R11: Status inputs pass through a two-flop synchronizer. A value is acted on only after it has been read the same on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request for a conversion |
| azero_req_i | input | 1 | Request for an auto-zero |
| busy_o | output | 1 | High when a start request would not be accepted |
| result_ob_o | output | 22 | Last result in offset binary |
| result_sgn_o | output | 24 | Last result in two's complement |
| valid_o | output | 1 | One-cycle pulse with each new result |
| err_o | output | 1 | Set by a status timeout |
| adc_conv_n_o | output | 1 | Active-low convert strobe |
| adc_az_n_o | output | 1 | Active-low auto-zero request |
| adc_oe_n_o | output | 1 | Active-low output enable for the data bus |
| adc_status_i | input | 2 | Converter status code |
| adc_data_i | input | 8 | Shared byte-wide data bus |

## Verification
A status change reaches the sequencer's decisions on the fourth rising edge after it appears: two synchronizer stages, one edge for the agreement compare, and one edge to update the filtered value. So `busy_o` and each strobe decision trail the responder by that much. A convert strobe falls on the edge that samples an accepted `start_i`. `valid_o` and the new results appear one edge after the last clock of the third output-enable window.

The bench avoids relying on exact edges for these multi-edge paths. Its responder changes status on falling clock edges. Its reference monitor, also on the falling edge, measures every strobe and enable window width and pops the expected code from a queue whenever `valid_o` is high. The tasks that drive stimulus read the monitor's counters on the rising edge, half a cycle after the monitor updates them.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    // Status codes reported by the converter
    localparam logic [1:0] STS_WORKING = 2'b00;
    localparam logic [1:0] STS_READY   = 2'b11;

    // Width of the assembled offset-binary code
    localparam int CODE_W = 22;
    localparam int SGN_W  = 24;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AZ_LOW,
        ST_AZ_WAIT0,
        ST_AZ_WAIT1,
        ST_CONV_LOW,
        ST_WAIT,
        ST_READ
    } rd_state_e;

endpackage

// File: rtl/adc_status_filter.sv
module adc_status_filter #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] stable_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
        logic [W-1:0] filt;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d      = q;
        d.s1   = raw_i;
        d.s2   = q.s1;
        d.s3   = q.s2;
        // take the synchronized value only once two successive samples agree
        if (q.s2 == q.s3) begin
            d.filt = q.s2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign stable_o = q.filt;

endmodule

// File: rtl/adc_wait_timer.sv
module adc_wait_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);

    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] cnt_q, cnt_d;

    assign expired_o = run_i && (cnt_q == LAST);

    always_comb begin
        if (!run_i || expired_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/adc_code_fmt.sv
module adc_code_fmt
    import adc_rd_pkg::*;
(
    input  logic [5:0]        top_i,
    input  logic [BYTE_W-1:0] mid_i,
    input  logic [BYTE_W-1:0] low_i,
    output logic [CODE_W-1:0] code_o,
    output logic [SGN_W-1:0]  sgn_o
);

    localparam int EXT = SGN_W - CODE_W;

    always_comb begin
        code_o = {top_i, mid_i, low_i};
        // offset binary to two's complement: flip the top code bit, extend it
        sgn_o  = {{EXT{~code_o[CODE_W-1]}}, ~code_o[CODE_W-1], code_o[CODE_W-2:0]};
    end

endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl
    import adc_rd_pkg::*;
#(
    parameter int CONV_LOW = 3,
    parameter int SETTLE   = 2,
    parameter int AZ_LOW   = 4,
    parameter int TIMEOUT  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              azero_req_i,
    output logic              busy_o,
    output logic [CODE_W-1:0] result_ob_o,
    output logic [SGN_W-1:0]  result_sgn_o,
    output logic              valid_o,
    output logic              err_o,
    output logic              adc_conv_n_o,
    output logic              adc_az_n_o,
    output logic              adc_oe_n_o,
    input  logic [1:0]        adc_status_i,
    input  logic [BYTE_W-1:0] adc_data_i
);

    localparam int M1    = (CONV_LOW > SETTLE) ? CONV_LOW : SETTLE;
    localparam int PMAX  = (M1 > AZ_LOW) ? M1 : AZ_LOW;
    localparam int CNT_W = $clog2(PMAX + 1);
    localparam logic [CNT_W-1:0] CONV_LAST   = CNT_W'(CONV_LOW - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE - 1);
    localparam logic [CNT_W-1:0] AZ_LAST     = CNT_W'(AZ_LOW - 1);

    typedef struct packed {
        rd_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        idx;
        logic [5:0]        top;
        logic [BYTE_W-1:0] mid;
        logic [CODE_W-1:0] ob;
        logic [SGN_W-1:0]  sgn;
        logic              valid;
        logic              err;
        logic              az_pend;
        logic              conv_n;
        logic              oe_n;
        logic              az_n;
    } regs_t;

    regs_t q, d;

    logic [1:0]        sts;
    logic              tmo_run;
    logic              tmo_expired;
    logic [CODE_W-1:0] fmt_code;
    logic [SGN_W-1:0]  fmt_sgn;

    adc_status_filter #(.W(2)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_i    (adc_status_i),
        .stable_o (sts)
    );

    assign tmo_run = (q.st == ST_WAIT) || (q.st == ST_AZ_WAIT0) || (q.st == ST_AZ_WAIT1);

    adc_wait_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (tmo_run),
        .expired_o (tmo_expired)
    );

    // the low byte comes straight from the bus in the capture cycle
    adc_code_fmt u_fmt (
        .top_i  (q.top),
        .mid_i  (q.mid),
        .low_i  (adc_data_i),
        .code_o (fmt_code),
        .sgn_o  (fmt_sgn)
    );

    always_comb begin
        d       = q;
        d.valid = 1'b0;

        if (azero_req_i) begin
            d.az_pend = 1'b1;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (q.az_pend || azero_req_i) begin
                    d.st      = ST_AZ_LOW;
                    d.az_n    = 1'b0;
                    d.cnt     = '0;
                    d.err     = 1'b0;
                    d.az_pend = 1'b0;
                end else if (start_i && (sts == STS_READY)) begin
                    d.st     = ST_CONV_LOW;
                    d.conv_n = 1'b0;
                    d.cnt    = '0;
                    d.idx    = 2'd0;
                    d.err    = 1'b0;
                end
            end
            ST_AZ_LOW: begin
                if (q.cnt == AZ_LAST) begin
                    d.az_n = 1'b1;
                    d.st   = ST_AZ_WAIT0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_AZ_WAIT0: begin
                // the converter must first report that it is busy zeroing
                if (sts == STS_WORKING) begin
                    d.st = ST_AZ_WAIT1;
                end
            end
            ST_AZ_WAIT1: begin
                if (sts == STS_READY) begin
                    d.st = ST_IDLE;
                end
            end
            ST_CONV_LOW: begin
                if (q.cnt == CONV_LAST) begin
                    d.conv_n = 1'b1;
                    d.st     = ST_WAIT;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            ST_WAIT: begin
                // byte k is announced by status code k+1
                if (sts == (q.idx + 2'd1)) begin
                    d.st   = ST_READ;
                    d.oe_n = 1'b0;
                    d.cnt  = '0;
                end
            end
            ST_READ: begin
                if (q.cnt == SETTLE_LAST) begin
                    d.oe_n = 1'b1;
                    if (q.idx == 2'd2) begin
                        d.ob    = fmt_code;
                        d.sgn   = fmt_sgn;
                        d.valid = 1'b1;
                        d.st    = ST_IDLE;
                    end else begin
                        if (q.idx == 2'd0) begin
                            d.top = adc_data_i[5:0];
                        end else begin
                            d.mid = adc_data_i;
                        end
                        d.idx    = q.idx + 2'd1;
                        d.st     = ST_CONV_LOW;
                        d.conv_n = 1'b0;
                        d.cnt    = '0;
                    end
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase

        if (tmo_expired) begin
            d.st     = ST_IDLE;
            d.err    = 1'b1;
            d.conv_n = 1'b1;
            d.oe_n   = 1'b1;
            d.az_n   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.cnt     <= '0;
            q.idx     <= 2'd0;
            q.top     <= '0;
            q.mid     <= '0;
            q.ob      <= '0;
            q.sgn     <= '0;
            q.valid   <= 1'b0;
            q.err     <= 1'b0;
            q.az_pend <= 1'b0;
            q.conv_n  <= 1'b1;
            q.oe_n    <= 1'b1;
            q.az_n    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy_o       = (q.st != ST_IDLE) || (sts != STS_READY) || q.az_pend;
    assign result_ob_o  = q.ob;
    assign result_sgn_o = q.sgn;
    assign valid_o      = q.valid;
    assign err_o        = q.err;
    assign adc_conv_n_o = q.conv_n;
    assign adc_az_n_o   = q.az_n;
    assign adc_oe_n_o   = q.oe_n;

endmodule

module adc_readout_chk (
    input logic clk,
    input logic rst_n,
    input logic busy_o,
    input logic valid_o,
    input logic adc_conv_n_o,
    input logic adc_oe_n_o,
    input logic adc_az_n_o
);

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!adc_oe_n_o && !adc_conv_n_o));

    // R4
    oe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_oe_n_o |-> busy_o);

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R3
    conv_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_conv_n_o) |=> !adc_conv_n_o);

    // R8
    az_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_az_n_o |-> (adc_conv_n_o && adc_oe_n_o));

endmodule

bind adc_readout_ctrl adc_readout_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_o       (busy_o),
    .valid_o      (valid_o),
    .adc_conv_n_o (adc_conv_n_o),
    .adc_oe_n_o   (adc_oe_n_o),
    .adc_az_n_o   (adc_az_n_o)
);

// File: tb/adc_readout_ctrl_tb_top.sv
module adc_readout_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CONV_LOW   = 3;
    localparam int SETTLE     = 2;
    localparam int AZ_LOW     = 4;
    localparam int TIMEOUT    = 48;
    localparam int CONV_DLY   = 10;
    localparam int AZ_DLY     = 6;
    localparam int WD_LIMIT   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        az_req = 1'b0;
    logic        busy;
    logic [21:0] ob;
    logic [23:0] sgn;
    logic        valid;
    logic        err;
    logic        conv_n, az_n, oe_n;
    logic [1:0]  sts = 2'b11;
    logic [7:0]  data;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_readout_ctrl #(
        .CONV_LOW(CONV_LOW), .SETTLE(SETTLE), .AZ_LOW(AZ_LOW), .TIMEOUT(TIMEOUT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .azero_req_i(az_req),
        .busy_o(busy), .result_ob_o(ob), .result_sgn_o(sgn), .valid_o(valid),
        .err_o(err), .adc_conv_n_o(conv_n), .adc_az_n_o(az_n), .adc_oe_n_o(oe_n),
        .adc_status_i(sts), .adc_data_i(data)
    );

    int total = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- converter responder ----------------
    logic [7:0] top_b = 8'h00, mid_b = 8'h00, low_b = 8'h00;
    bit         stall = 1'b0;
    logic       rsp_conv_p = 1'b1;
    int         dly = 0;
    logic [1:0] pend = 2'b11;

    always_comb begin
        if (oe_n) data = 8'hzz;
        else if (sts == 2'b01) data = top_b;
        else if (sts == 2'b10) data = mid_b;
        else data = low_b;
    end

    always @(negedge clk) begin
        if (!az_n) begin
            sts  = 2'b00;
            pend = 2'b11;
            dly  = AZ_DLY;
        end else if (rsp_conv_p && !conv_n) begin
            case (sts)
                2'b11: begin sts = 2'b00; pend = 2'b01; dly = stall ? -1 : CONV_DLY; end
                2'b01: begin pend = 2'b10; dly = 2; end
                2'b10: begin pend = 2'b11; dly = 2; end
                default: ;
            endcase
        end else if (dly > 0) begin
            dly--;
            if (dly == 0) sts = pend;
        end
        rsp_conv_p = conv_n;
    end

    // ---------------- reference monitor ----------------
    int unsigned exp_q[$];
    int conv_run = 0, oe_run = 0, az_run = 0;
    int n_conv = 0, n_oe = 0, n_az = 0, n_valid = 0;
    logic mon_conv_p = 1'b1, valid_p = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_conv_p && !conv_n) n_conv++;
            mon_conv_p = conv_n;
            if (!conv_n) conv_run++;
            else if (conv_run != 0) begin
                chk(conv_run == CONV_LOW, "R3", "convert strobe width", conv_run, CONV_LOW);
                conv_run = 0;
            end
            if (!oe_n) oe_run++;
            else if (oe_run != 0) begin
                chk(oe_run == SETTLE, "R4", "output enable width", oe_run, SETTLE);
                n_oe++;
                oe_run = 0;
            end
            if (!az_n) az_run++;
            else if (az_run != 0) begin
                chk(az_run == AZ_LOW, "R8", "auto-zero width", az_run, AZ_LOW);
                n_az++;
                az_run = 0;
            end
            if (!oe_n && (!conv_n || !az_n))
                chk(1'b0, "R4", "enable low with a strobe", 1, 0);
            if (valid && valid_p)
                chk(1'b0, "R7", "valid longer than one clock", 2, 1);
            if (valid) begin
                n_valid++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected valid", 1, 0);
                end else begin
                    automatic int unsigned e = exp_q.pop_front();
                    chk(ob == e[21:0], "R5", "offset-binary result", ob, e);
                    chk($signed(sgn) == (int'(e) - 2097152), "R6", "signed result",
                        $signed(sgn), int'(e) - 2097152);
                end
            end
            valid_p = valid;
        end
    end

    // ---------------- watchdog ----------------
    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles >= WD_LIMIT) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WD_LIMIT);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // ---------------- tasks ----------------
    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_az();
        @(negedge clk); az_req = 1'b1;
        @(negedge clk); az_req = 1'b0;
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        @(negedge clk);
        while (busy && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(!busy, req, "ready reached", busy, 0);
    endtask

    task automatic wait_valid_count(input int target);
        int n = 0;
        while (n_valid < target && n < 2000) begin
            @(posedge clk);
            n++;
        end
        chk(n_valid == target, "R7", "valid count", n_valid, target);
    endtask

    task automatic do_conv(input logic [21:0] code, input logic [1:0] junk);
        int c0, o0, v0;
        wait_ready("R2");
        top_b = {junk, code[21:16]};
        mid_b = code[15:8];
        low_b = code[7:0];
        exp_q.push_back(32'(code));
        @(posedge clk);
        c0 = n_conv; o0 = n_oe; v0 = n_valid;
        pulse_start();
        wait_valid_count(v0 + 1);
        @(posedge clk);
        chk(n_conv - c0 == 3, "R3", "strobes per conversion", n_conv - c0, 3);
        chk(n_oe - o0 == 3, "R4", "enable windows per conversion", n_oe - o0, 3);
        repeat (3) @(negedge clk);
        chk(ob == code, "R7", "result held after valid", ob, code);
        chk(!valid, "R7", "valid low after pulse", valid, 0);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int c0, a0, v0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(conv_n && az_n && oe_n, "R1", "strobes high in reset", {conv_n, az_n, oe_n}, 7);
        chk(!valid && !err, "R1", "valid and err low in reset", {valid, err}, 0);
        chk(busy, "R1", "busy in reset", busy, 1);
        rst_n = 1'b1;
        // R11: after the status settles through the filter the block turns ready
        @(negedge clk);
        chk(busy, "R11", "busy right after reset before status filtered", busy, 1);
        wait_ready("R11");

        do_conv(22'h000000, 2'b00);
        do_conv(22'h200000, 2'b00);
        do_conv(22'h3FFFFF, 2'b00);
        do_conv(22'h155AA5, 2'b11);   // R5 junk top bits ignored
        do_conv(22'h2ABC12, 2'b10);   // R5

        // R8 plain auto-zero
        @(posedge clk); a0 = n_az;
        pulse_az();
        wait_ready("R8");
        @(posedge clk);
        chk(n_az == a0 + 1, "R8", "auto-zero performed", n_az - a0, 1);

        // R2 start during auto-zero ignored
        @(posedge clk); c0 = n_conv; a0 = n_az;
        pulse_az();
        pulse_start();
        wait_ready("R2");
        @(posedge clk);
        chk(n_conv == c0, "R2", "no strobe from start during auto-zero", n_conv - c0, 0);
        chk(n_az == a0 + 1, "R2", "auto-zero completed", n_az - a0, 1);

        // R8 simultaneous requests: auto-zero wins
        @(posedge clk); c0 = n_conv; a0 = n_az;
        @(negedge clk); az_req = 1'b1; start = 1'b1;
        @(negedge clk); az_req = 1'b0; start = 1'b0;
        wait_ready("R8");
        @(posedge clk);
        chk(n_conv == c0, "R8", "start dropped on tie", n_conv - c0, 0);
        chk(n_az == a0 + 1, "R8", "auto-zero taken on tie", n_az - a0, 1);

        // R9 auto-zero requested mid-conversion
        top_b = 8'h12; mid_b = 8'h34; low_b = 8'h56;
        exp_q.push_back(32'h123456);
        @(posedge clk); c0 = n_conv; a0 = n_az; v0 = n_valid;
        pulse_start();
        while (n_conv < c0 + 2) @(posedge clk);
        pulse_az();
        @(negedge clk);
        chk(busy, "R9", "busy while auto-zero pending", busy, 1);
        wait_valid_count(v0 + 1);
        @(posedge clk);
        chk(n_az == a0, "R9", "no auto-zero during conversion", n_az - a0, 0);
        wait_ready("R9");
        @(posedge clk);
        chk(n_az == a0 + 1, "R9", "pending auto-zero done afterwards", n_az - a0, 1);

        // R10 timeout
        stall = 1'b1;
        @(posedge clk); c0 = n_conv;
        pulse_start();
        begin
            int n = 0;
            while (!err && n < 400) begin @(posedge clk); n++; end
        end
        @(negedge clk);
        chk(err, "R10", "error flag after timeout", err, 1);
        chk(conv_n && oe_n && az_n, "R10", "strobes released", {conv_n, oe_n, az_n}, 7);
        chk(busy, "R10", "busy while status not ready", busy, 1);
        // R2 start with status not ready is ignored
        pulse_start();
        repeat (10) @(negedge clk);
        chk(n_conv == c0 + 1, "R2", "no strobe while status not ready", n_conv - c0, 1);
        chk(err, "R10", "error held until accepted request", err, 1);
        stall = 1'b0;
        pulse_az();
        wait_ready("R10");
        chk(!err, "R10", "error cleared by auto-zero", err, 0);

        do_conv(22'h0F0F0F, 2'b01);

        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "all expected results seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule